// File: doc/BRIEF.md
# NAND Command and Address Cycle Sequencer

This block sits between a flash transaction controller and the pins of a large-page NAND device with an 8- or 16-bit bus. For each request it puts one command byte or a group of address bytes on the data lines. Each byte gets a write-enable pulse of programmed width, framed by command-latch-enable or address-latch-enable. The block then waits for the device's ready/busy line and pulses `done`.

A request chooses one of four kinds:

- a command byte;
- the two column bytes;
- the page bytes;
- the column bytes followed by the page bytes.

A spare-area flag sets one bit in the second column byte. Which bit it sets depends on the bus width. A third page byte is sent only when the configured capacity is above 128 MiB.

A reset command gets extra handling. After it, the block issues the status command on its own and keeps pulsing read-enable until the ready bit of the status byte reads 1. Chip-enable follows a separate input, so a higher-level controller can hold the device selected across a whole transaction.

Top module: `nand_cycle_seq`

## Requirements
- R1: A command request (`req_kind`=0) sends `req_cmd` as one byte on `nand_dq_out[7:0]`, with `nand_cle`=1 and `nand_ale`=0. The byte gets one `nand_we_n` low pulse of WE_LOW_CLKS clocks, followed by WE_HIGH_CLKS clocks high, and the data stays stable while the strobe is low.
- R2: A column request (`req_kind`=1) sends two bytes with `nand_ale`=1 and `nand_cle`=0. The first byte is offset bits 7:0. The second byte carries offset bits 10:8 in its bits 2:0, and its other bits are 0 unless R3 applies.
- R3: When `req_spare`=1 and the request includes column bytes, the second column byte also has one flag bit set: bit 3 for an 8-bit device (WIDE16=0) and bit 2 for a 16-bit device. A page-only request ignores `req_spare`.
- R4: A page request (`req_kind`=2) sends offset bits 18:11, then bits 26:19. Only when CAPACITY_MB > 128 does it also send bits 34:27 as a third byte.
- R5: A combined request (`req_kind`=3) sends both column bytes first and then the page bytes, all under `nand_ale`.
- R6: After the reset command 0xFF, the block sends the status command 0x70 under `nand_cle`. It then pulses `nand_re_n` low once per status read, samples `nand_dq_in[6]` during each pulse, and stops after the first read that returns 1.
- R7: After the last byte of a phase, `done` does not pulse while `nand_rb` is 0. Once `nand_rb` is 1, `done` pulses for exactly one cycle.
- R8: `nand_cle` and `nand_ale` are never both 1, and `nand_re_n` is low only while both are 0.
- R9: `nand_ce_n` is the inverse of `ce_hold` at all times, including during a sequence.
- R10: `req_valid` is ignored while `busy`=1, including the cycle in which `done` is 1.
- R11: After reset the outputs are idle: `nand_cle`=0, `nand_ale`=0, `nand_we_n`=1, `nand_re_n`=1, `nand_dq_oe`=0, `busy`=0, `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a request (accepted only when idle) |
| req_kind | input | 2 | 0 command, 1 column, 2 page, 3 column+page |
| req_spare | input | 1 | Spare-area flag for column bytes |
| req_cmd | input | 8 | Command byte |
| req_offset | input | 35 | Byte offset used to form the address bytes |
| ce_hold | input | 1 | Keep the device selected |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| nand_dq_in | input | 16 | Data read from the device (status byte) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data driven to the device (upper byte 0) |
| nand_dq_oe | output | 1 | Data output enable |

## Verification
The completion pulse can fall in the same cycle as a new request. The bench raises `req_valid` in exactly the cycle where `done` is seen high. It then checks that no further strobe, latch or `busy` activity follows, because a request in that cycle must be dropped.

A second overlap comes up in the status loop. The ready bit can already be 1 on the first read, which ends the poll and starts the wait on the same strobe. The bench counts read pulses against the read index at which it first reports ready.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    localparam int OFFSET_W = 35;
    localparam int ADDR_BYTES_MAX = 5;
    localparam int PAGE_BYTES_MAX = 3;

    typedef enum logic [1:0] {
        REQ_CMD  = 2'd0,
        REQ_COL  = 2'd1,
        REQ_PAGE = 2'd2,
        REQ_BOTH = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_STAT_CMD,
        S_POLL,
        S_WAIT,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/nand_addr_builder.sv
module nand_addr_builder
    import nand_seq_pkg::*;
#(
    parameter bit WIDE16      = 1'b0,
    parameter int CAPACITY_MB = 256
) (
    input  logic [1:0]                     kind,
    input  logic                           spare,
    input  logic [OFFSET_W-1:0]            offset,
    output logic [ADDR_BYTES_MAX-1:0][7:0] bytes,
    output logic [2:0]                     nbytes
);
    localparam int FLAG_BIT = WIDE16 ? 2 : 3;
    localparam int PAGE_N   = (CAPACITY_MB > 128) ? 3 : 2;

    logic [7:0] col_lo, col_hi;
    logic [PAGE_BYTES_MAX-1:0][7:0] pg;

    always_comb begin
        col_lo = offset[7:0];
        col_hi = {5'b0, offset[10:8]};
        if (spare) col_hi[FLAG_BIT] = 1'b1;
        for (int i = 0; i < PAGE_BYTES_MAX; i++) begin
            pg[i] = offset[11 + 8*i +: 8];
        end
    end

    always_comb begin
        bytes  = '0;
        nbytes = '0;
        case (req_kind_e'(kind))
            REQ_COL: begin
                bytes[0] = col_lo;
                bytes[1] = col_hi;
                nbytes   = 3'd2;
            end
            REQ_PAGE: begin
                for (int i = 0; i < PAGE_N; i++) bytes[i] = pg[i];
                nbytes = 3'(PAGE_N);
            end
            REQ_BOTH: begin
                bytes[0] = col_lo;
                bytes[1] = col_hi;
                for (int i = 0; i < PAGE_N; i++) bytes[2+i] = pg[i];
                nbytes = 3'(2 + PAGE_N);
            end
            default: nbytes = '0;
        endcase
    end
endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
    parameter int LOW_CLKS  = 2,
    parameter int HIGH_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic active_low,
    output logic sample,
    output logic byte_end
);
    localparam int TOT = LOW_CLKS + HIGH_CLKS;
    localparam int CW  = $clog2(TOT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    assign active_low = run && (tmr_q.cnt < CW'(LOW_CLKS));
    assign sample     = run && (tmr_q.cnt == CW'(LOW_CLKS - 1));
    assign byte_end   = run && (tmr_q.cnt == CW'(TOT - 1));

    always_comb begin
        tmr_d = tmr_q;
        if (!run || byte_end) tmr_d.cnt = '0;
        else                  tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // the low phase always ends on the sampling cycle
    assert_low_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(active_low) && !active_low) |-> $past(sample));
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter bit         WIDE16       = 1'b0,
    parameter int         CAPACITY_MB  = 256,
    parameter int         WE_LOW_CLKS  = 2,
    parameter int         WE_HIGH_CLKS = 2,
    parameter logic [7:0] RESET_CMD    = 8'hFF,
    parameter logic [7:0] STATUS_CMD   = 8'h70,
    parameter int         READY_BIT    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic                req_spare,
    input  logic [7:0]          req_cmd,
    input  logic [OFFSET_W-1:0] req_offset,
    input  logic                ce_hold,
    input  logic                nand_rb,
    input  logic [15:0]         nand_dq_in,
    output logic                busy,
    output logic                done,
    output logic                nand_ce_n,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic [15:0]         nand_dq_out,
    output logic                nand_dq_oe
);
    typedef struct packed {
        seq_state_e                     state;
        logic [2:0]                     idx;
        logic [2:0]                     last;
        logic [7:0]                     cmd;
        logic [ADDR_BYTES_MAX-1:0][7:0] bytes;
        logic                           rdy;
    } seq_t;

    seq_t q, d;

    logic [ADDR_BYTES_MAX-1:0][7:0] bld_bytes;
    logic [2:0] bld_n;
    logic run, strobe_low, strobe_sample, byte_end;
    logic write_phase;
    logic [7:0] cur_byte;
    logic dq_unused;

    nand_addr_builder #(.WIDE16(WIDE16), .CAPACITY_MB(CAPACITY_MB)) u_builder (
        .kind(req_kind), .spare(req_spare), .offset(req_offset),
        .bytes(bld_bytes), .nbytes(bld_n)
    );

    assign run = (q.state == S_CMD) || (q.state == S_ADDR) ||
                 (q.state == S_STAT_CMD) || (q.state == S_POLL);

    nand_strobe_timer #(.LOW_CLKS(WE_LOW_CLKS), .HIGH_CLKS(WE_HIGH_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run),
        .active_low(strobe_low), .sample(strobe_sample), .byte_end(byte_end)
    );

    assign dq_unused = ^nand_dq_in;

    always_comb begin
        d = q;
        case (q.state)
            S_IDLE: if (req_valid) begin
                d.cmd   = req_cmd;
                d.bytes = bld_bytes;
                d.last  = 3'(bld_n - 3'd1);
                d.idx   = '0;
                d.rdy   = 1'b0;
                if (req_kind_e'(req_kind) == REQ_CMD) d.state = S_CMD;
                else if (bld_n != '0)                 d.state = S_ADDR;
            end
            S_CMD: if (byte_end)
                d.state = (q.cmd == RESET_CMD) ? S_STAT_CMD : S_WAIT;
            S_ADDR: if (byte_end) begin
                if (q.idx == q.last) d.state = S_WAIT;
                else                 d.idx   = q.idx + 3'd1;
            end
            S_STAT_CMD: begin
                d.rdy = 1'b0;
                if (byte_end) d.state = S_POLL;
            end
            S_POLL: begin
                if (strobe_sample) d.rdy = nand_dq_in[READY_BIT];
                if (byte_end && q.rdy) d.state = S_WAIT;
            end
            S_WAIT: if (nand_rb) d.state = S_DONE;
            S_DONE: d.state = S_IDLE;
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.state)
            S_CMD:      cur_byte = q.cmd;
            S_ADDR:     cur_byte = q.bytes[q.idx];
            S_STAT_CMD: cur_byte = STATUS_CMD;
            default:    cur_byte = 8'h00;
        endcase
    end

    assign write_phase = (q.state == S_CMD) || (q.state == S_ADDR) || (q.state == S_STAT_CMD);
    assign busy        = (q.state != S_IDLE);
    assign done        = (q.state == S_DONE);
    assign nand_ce_n   = !ce_hold;
    assign nand_cle    = (q.state == S_CMD) || (q.state == S_STAT_CMD);
    assign nand_ale    = (q.state == S_ADDR);
    assign nand_we_n   = !(write_phase && strobe_low);
    assign nand_re_n   = !((q.state == S_POLL) && strobe_low);
    assign nand_dq_out = {8'h00, cur_byte};
    assign nand_dq_oe  = write_phase;

    assert_latch_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    assert_re_no_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> (!nand_cle && !nand_ale));
    assert_done_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(nand_rb));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_dq_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && !nand_dq_oe));
endmodule

// File: tb/test_nand_cycle_seq.sv
`timescale 1ns/1ps
module test_nand_cycle_seq;
    localparam int LOWC = 2;
    localparam int HIGHC = 2;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_spare = 0, ce_hold = 0, nand_rb = 1;
    logic [1:0] req_kind = 0;
    logic [7:0] req_cmd = 0;
    logic [34:0] req_offset = 0;
    logic [15:0] nand_dq_in;
    logic busy, done, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;

    int checks = 0, errors = 0;
    int log_n = 0, width_err = 0, excl_err = 0, rd_idx = 0, need = 1, we_len = 0;
    logic [7:0] log_b [16];
    logic log_c [16];
    logic log_a [16];
    logic [7:0] exp_b [8];
    logic exp_c [8];
    int exp_n;
    logic prev_we = 1, prev_re = 1;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign nand_dq_in = (rd_idx >= need) ? 16'h0040 : 16'h0000;

    nand_cycle_seq #(.WIDE16(1'b0), .CAPACITY_MB(256), .WE_LOW_CLKS(LOWC), .WE_HIGH_CLKS(HIGHC))
    i_nand_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_spare(req_spare), .req_cmd(req_cmd), .req_offset(req_offset),
        .ce_hold(ce_hold), .nand_rb(nand_rb), .nand_dq_in(nand_dq_in),
        .busy(busy), .done(done), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
    );

    always @(negedge clk) begin
        if (nand_cle && nand_ale) excl_err++;
        if (!nand_re_n && (nand_cle || nand_ale)) excl_err++;
        if (!nand_we_n) we_len++;
        if (nand_we_n && !prev_we) begin
            if (log_n < 16) begin
                log_b[log_n] = nand_dq_out[7:0];
                log_c[log_n] = nand_cle;
                log_a[log_n] = nand_ale;
            end
            if (we_len != LOWC) width_err++;
            we_len = 0;
            log_n++;
        end
        if (!nand_re_n && prev_re) rd_idx++;
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build_exp(logic [1:0] kind, logic spare, logic [7:0] cmd, logic [34:0] off);
        logic [7:0] c1;
        c1 = {5'b0, off[10:8]} | (spare ? 8'h08 : 8'h00);
        exp_n = 0;
        if (kind == 2'd0) begin
            exp_b[0] = cmd; exp_c[0] = 1; exp_n = 1;
            if (cmd == 8'hFF) begin exp_b[1] = 8'h70; exp_c[1] = 1; exp_n = 2; end
        end else begin
            if (kind[0]) begin
                exp_b[exp_n] = off[7:0]; exp_c[exp_n] = 0; exp_n++;
                exp_b[exp_n] = c1; exp_c[exp_n] = 0; exp_n++;
            end
            if (kind[1]) begin
                exp_b[exp_n] = off[18:11]; exp_c[exp_n] = 0; exp_n++;
                exp_b[exp_n] = off[26:19]; exp_c[exp_n] = 0; exp_n++;
                exp_b[exp_n] = off[34:27]; exp_c[exp_n] = 0; exp_n++;
            end
        end
    endtask

    task automatic start_req(logic [1:0] kind, logic spare, logic [7:0] cmd, logic [34:0] off);
        @(negedge clk);
        log_n = 0; width_err = 0; rd_idx = 0;
        req_kind = kind; req_spare = spare; req_cmd = cmd; req_offset = off;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    endtask

    task automatic compare(string req);
        check(log_n == exp_n, req, "byte count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            check(log_b[i] == exp_b[i], req, $sformatf("byte %0d", i), log_b[i], exp_b[i]);
            check(log_c[i] == exp_c[i] && log_a[i] == !exp_c[i], req,
                  $sformatf("latch %0d", i), {log_c[i], log_a[i]}, {exp_c[i], !exp_c[i]});
        end
        check(width_err == 0, "R1", "strobe low width errors", width_err, 0);
    endtask

    task automatic run_req(string req, logic [1:0] kind, logic spare, logic [7:0] cmd, logic [34:0] off);
        int cyc;
        build_exp(kind, spare, cmd, off);
        start_req(kind, spare, cmd, off);
        wait_done(cyc);
        check(done == 1, req, "done seen", done, 1);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [34:0] roff;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11 reset state
        check({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, busy, done} == 7'b0011000,
              "R11", "idle outputs in reset",
              {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, busy, done}, 7'b0011000);
        rst_n = 1;
        @(negedge clk);
        check({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, busy, done} == 7'b0011000,
              "R11", "idle outputs after reset",
              {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, busy, done}, 7'b0011000);
        // R9 chip enable follows ce_hold
        ce_hold = 1; #1;
        check(nand_ce_n == 0, "R9", "ce_n with hold", nand_ce_n, 0);
        ce_hold = 0; #1;
        check(nand_ce_n == 1, "R9", "ce_n without hold", nand_ce_n, 1);

        run_req("R1", 2'd0, 0, 8'h00, '0);
        run_req("R1", 2'd0, 0, 8'h30, '0);
        run_req("R2", 2'd1, 0, 8'h00, 35'h7_FFFF_F5A3);
        run_req("R3", 2'd1, 1, 8'h00, 35'h0_0000_05A3);
        run_req("R3", 2'd2, 1, 8'h00, 35'h5_1234_5678);
        run_req("R4", 2'd2, 0, 8'h00, 35'h2_ABCD_EF01);
        run_req("R5", 2'd3, 1, 8'h00, 35'h7_8001_07FF);

        // R6 reset command, ready on third status read
        need = 3;
        run_req("R6", 2'd0, 0, 8'hFF, '0);
        check(rd_idx == 3, "R6", "status reads", rd_idx, 3);
        need = 1;
        run_req("R6", 2'd0, 0, 8'hFF, '0);
        check(rd_idx == 1, "R6", "status reads ready first", rd_idx, 1);

        // R7 wait on ready/busy
        nand_rb = 0;
        build_exp(2'd0, 0, 8'h80, '0);
        start_req(2'd0, 0, 8'h80, '0);
        begin
            int seen = 0;
            repeat (30) begin @(negedge clk); if (done) seen++; end
            check(seen == 0, "R7", "done while busy line low", seen, 0);
            check(busy == 1, "R7", "still busy", busy, 1);
        end
        nand_rb = 1;
        wait_done(cyc);
        check(cyc <= 3, "R7", "done latency after ready", cyc, 3);
        @(negedge clk);
        check(done == 0, "R7", "done one cycle", done, 0);
        compare("R7");

        // R10 request while busy ignored
        build_exp(2'd1, 0, 8'h00, 35'h0_0000_0312);
        start_req(2'd1, 0, 8'h00, 35'h0_0000_0312);
        repeat (2) @(negedge clk);
        req_kind = 2'd0; req_cmd = 8'h90; req_valid = 1;
        @(negedge clk); req_valid = 0;
        wait_done(cyc);
        @(negedge clk);
        compare("R10");

        // R10 request in the done cycle
        start_req(2'd0, 0, 8'h55, '0);
        wait_done(cyc);
        req_kind = 2'd3; req_valid = 1;
        @(negedge clk); req_valid = 0;
        log_n = 0;
        repeat (40) @(negedge clk);
        check(log_n == 0, "R10", "strobes after done-cycle request", log_n, 0);
        check(busy == 0, "R10", "busy after done-cycle request", busy, 0);

        // random mix
        ce_hold = 1;
        for (int k = 0; k < 40; k++) begin
            logic [1:0] kd;
            kd = 2'($urandom_range(3, 0));
            roff = {3'($urandom), 32'($urandom)};
            run_req(kd == 0 ? "R1" : kd == 1 ? "R2" : kd == 2 ? "R4" : "R5",
                    kd, 1'($urandom), 8'($urandom_range(8'hFE, 0)), roff);
            check(nand_ce_n == 0, "R9", "ce_n held during run", nand_ce_n, 0);
        end
        check(excl_err == 0, "R8", "latch exclusivity violations", excl_err, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule